// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block arbitrates interrupts for a small 8-bit microcontroller core. Six sources feed it: a falling edge on an external interrupt pin, overflow strobes from two timers, four USB event strobes that share one request, and completion strobes from two serial interfaces. Each source event is latched into a request flag. Two 8-bit control registers hold those flags beside per-source enable bits and a global enable. Software reads and writes both registers through a simple write strobe and byte-wide read-back ports.

When the global enable is set, at least one enabled flag is pending, the return stack is not full and the core signals an instruction boundary, the block issues a one-cycle take pulse together with the vector address of the highest-priority pending source. On the same edge, hardware clears the serviced flag and the global enable. Further maskable interrupts therefore wait until software sets the global enable again, which is how nesting is allowed. Flags that arrive while the global enable is off stay pending. A wake-up output is raised whenever any request flag is set, whatever the global enable or the source enables hold.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00, and take_o, vector_o and wake_o are all 0.
- R2: Control register 0 (reg_sel_i=0) holds the global enable in bit 0. Bits 1, 2 and 3 are the enables for external, timer 0 and timer 1, and bits 4, 5 and 6 are their request flags. Bit 7 always reads 0.
- R3: Control register 1 (reg_sel_i=1) holds the enables for USB, serial 0 and serial 1 in bits 0, 1 and 2, and their request flags in bits 4, 5 and 6. Bits 3 and 7 always read 0.
- R4: The external flag is set on a clock edge where ext_irq_ni is sampled low after being sampled high. A rising edge, or a pin that stays low, sets nothing.
- R5: A one-cycle strobe on tmr0_ovf_i, tmr1_ovf_i, ser0_i or ser1_i sets its flag. A strobe on any bit of usb_evt_i sets the USB flag. The flag is visible on the read-back port one cycle after the strobe.
- R6: take_o is high for exactly one cycle. It rises in the cycle after a clock edge where the global enable was set, an enabled flag was pending, stack_full_i was low and insn_bound_i was high. It never rises otherwise.
- R7: The sources rank external > timer 0 > timer 1 > USB > serial 0 > serial 1. Their vectors are 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18, and the vector is presented on vector_o while take_o is high.
- R8: On the edge that produces a take, the global enable and the serviced flag are cleared. All other flags stay as they were.
- R9: While stack_full_i is high, no take occurs. The pending request is taken once stack_full_i falls.
- R10: Flags set while the global enable is 0 stay pending. If software sets the global enable again after a take, the next pending enabled source is taken.
- R11: When a software write and a hardware event address the same flag on the same edge, the flag ends up set.
- R12: wake_o is 1 exactly when at least one request flag is set, regardless of the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_irq_ni | input | 1 | External interrupt pin, active on a falling edge, already synchronous |
| tmr0_ovf_i | input | 1 | Timer 0 overflow strobe |
| tmr1_ovf_i | input | 1 | Timer 1 overflow strobe |
| usb_evt_i | input | 4 | USB event strobes: FIFO access, suspend, resume, bus reset |
| ser0_i | input | 1 | Serial interface 0 strobe |
| ser1_i | input | 1 | Serial interface 1 strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = control 0, 1 = control 1 |
| reg_wdata_i | input | 8 | Register write data |
| stack_full_i | input | 1 | Return stack has no free entry |
| insn_bound_i | input | 1 | Core is at an instruction boundary |
| ctl0_o | output | 8 | Control register 0 read-back |
| ctl1_o | output | 8 | Control register 1 read-back |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| vector_o | output | 8 | Vector address of the last take |
| wake_o | output | 1 | Wake-up request |

## Verification
The bench drives several mixes of simultaneous sources against different enable masks. A broken priority chain or an off-by-one vector step would show up there as a wrong vector, and a mask bit that is ignored would show up as a take that should not happen. Directed cases hold stack_full_i high with everything else ready, which catches a design that ignores the stack. They also keep insn_bound_i high across a take, which catches a pulse that does not end because the global enable was not cleared. Further cases collide a register write with a timer or USB strobe on the same edge, where a design with the wrong write priority loses the event. Finally, the bench holds the pin low across a software clear; a level-sensitive detector would set the flag again.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned USB_EVT = 4;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  // source index = priority rank (0 highest)
  localparam int unsigned IDX_EXT  = 0;
  localparam int unsigned IDX_TMR0 = 1;
  localparam int unsigned IDX_TMR1 = 2;
  localparam int unsigned IDX_USB  = 3;
  localparam int unsigned IDX_SER0 = 4;
  localparam int unsigned IDX_SER1 = 5;
  // register field layout
  localparam int unsigned NUM_GRP = 2;
  localparam int unsigned GRP     = NUM_SRC / NUM_GRP;
  localparam int unsigned EN0_LSB = 1;
  localparam int unsigned EN1_LSB = 0;
  localparam int unsigned FLG_LSB = 4;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_event_capture.sv
module irq_event_capture
  import irq_vec_pkg::*;
#(
  parameter int unsigned USB_EVT_W = USB_EVT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ext_irq_ni,
  input  logic                 tmr0_ovf_i,
  input  logic                 tmr1_ovf_i,
  input  logic [USB_EVT_W-1:0] usb_evt_i,
  input  logic                 ser0_i,
  input  logic                 ser1_i,
  output src_vec_t             set_o
);
  logic ext_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b1;
    else         ext_prev_q <= ext_irq_ni;
  end

  always_comb begin
    set_o           = '0;
    set_o[IDX_EXT]  = ext_prev_q & ~ext_irq_ni;
    set_o[IDX_TMR0] = tmr0_ovf_i;
    set_o[IDX_TMR1] = tmr1_ovf_i;
    set_o[IDX_USB]  = |usb_evt_i;
    set_o[IDX_SER0] = ser0_i;
    set_o[IDX_SER1] = ser1_i;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_vec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_GRP-1:0] wr_i,
  input  logic [7:0]         wdata_i,
  input  src_vec_t           set_i,
  input  src_vec_t           clr_i,
  input  logic               take_i,
  output logic               gie_o,
  output src_vec_t           en_o,
  output src_vec_t           flg_o
);
  logic     gie_q, gie_nxt;
  src_vec_t en_q, en_nxt, flg_q, flg_nxt;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int unsigned EN_LSB = (g == 0) ? EN0_LSB : EN1_LSB;
    logic [GRP-1:0] flg_base;
    assign en_nxt[g*GRP +: GRP] = wr_i[g] ? wdata_i[EN_LSB +: GRP] : en_q[g*GRP +: GRP];
    assign flg_base             = wr_i[g] ? wdata_i[FLG_LSB +: GRP] : flg_q[g*GRP +: GRP];
    // hardware set last: an event is never lost to a write or a take
    assign flg_nxt[g*GRP +: GRP] = (flg_base & ~clr_i[g*GRP +: GRP]) | set_i[g*GRP +: GRP];
  end

  // take clears the global enable even against a same-edge write
  assign gie_nxt = take_i ? 1'b0 : (wr_i[0] ? wdata_i[0] : gie_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      en_q  <= '0;
      flg_q <= '0;
    end else begin
      gie_q <= gie_nxt;
      en_q  <= en_nxt;
      flg_q <= flg_nxt;
    end
  end

  assign gie_o = gie_q;
  assign en_o  = en_q;
  assign flg_o = flg_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_vec_pkg::*;
(
  input  src_vec_t         pend_i,
  output logic             any_o,
  output src_vec_t         grant_o,
  output logic [IDX_W-1:0] idx_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    if (i == 0) begin : g_top
      assign grant_o[i] = pend_i[i];
    end else begin : g_rest
      assign grant_o[i] = pend_i[i] & ~|pend_i[i-1:0];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant_o[i]) idx_o = i[IDX_W-1:0];
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned      VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 'h04,
  parameter logic [VEC_W-1:0] VEC_STEP = 'h04
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_irq_ni,
  input  logic               tmr0_ovf_i,
  input  logic               tmr1_ovf_i,
  input  logic [USB_EVT-1:0] usb_evt_i,
  input  logic               ser0_i,
  input  logic               ser1_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [7:0]         reg_wdata_i,
  input  logic               stack_full_i,
  input  logic               insn_bound_i,
  output logic [7:0]         ctl0_o,
  output logic [7:0]         ctl1_o,
  output logic               take_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic               wake_o
);
  src_vec_t           set, en, flg, pend, grant, clr;
  logic               gie, any, take_req, take_q;
  logic [IDX_W-1:0]   win_idx;
  logic [VEC_W-1:0]   vec_q;
  logic [NUM_GRP-1:0] wr;

  assign wr = {reg_wr_i & reg_sel_i, reg_wr_i & ~reg_sel_i};

  irq_event_capture #(.USB_EVT_W(USB_EVT)) u_cap (
    .clk_i, .rst_ni, .ext_irq_ni, .tmr0_ovf_i, .tmr1_ovf_i,
    .usb_evt_i, .ser0_i, .ser1_i, .set_o(set)
  );

  irq_flag_bank u_bank (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i(reg_wdata_i),
    .set_i(set), .clr_i(clr), .take_i(take_req),
    .gie_o(gie), .en_o(en), .flg_o(flg)
  );

  assign pend = flg & en;

  irq_prio_arb u_arb (
    .pend_i(pend), .any_o(any), .grant_o(grant), .idx_o(win_idx)
  );

  assign take_req = gie & any & ~stack_full_i & insn_bound_i;
  assign clr      = take_req ? grant : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= take_req;
      if (take_req) vec_q <= VEC_BASE + VEC_W'(win_idx) * VEC_STEP;
    end
  end

  assign take_o   = take_q;
  assign vector_o = vec_q;
  assign wake_o   = |flg;
  assign ctl0_o   = {1'b0, flg[IDX_TMR1:IDX_EXT], en[IDX_TMR1:IDX_EXT], gie};
  assign ctl1_o   = {1'b0, flg[IDX_SER1:IDX_USB], 1'b0, en[IDX_SER1:IDX_USB]};
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tmr0_ovf_i,
  input logic       reg_wr_i,
  input logic       stack_full_i,
  input logic       insn_bound_i,
  input logic [7:0] ctl0_o,
  input logic [7:0] ctl1_o,
  input logic       take_o,
  input logic [7:0] vector_o
);
  AST_TAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o); // R6
  AST_TAKE_NEEDS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_o) |-> $past(!stack_full_i && insn_bound_i)); // R9
  AST_GIE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !ctl0_o[0]); // R8
  AST_VECTOR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vector_o[1:0] == 2'b00 && vector_o >= 8'h04 && vector_o <= 8'h18)); // R7
  AST_SPARE_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl0_o[7] && !ctl1_o[7] && !ctl1_o[3]); // R3
  AST_PENDING_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl0_o[0] && !reg_wr_i && ctl0_o[4]) |=> ctl0_o[4]); // R10
  AST_HW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr0_ovf_i |=> ctl0_o[5]); // R11
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tmr0_ovf_i(tmr0_ovf_i), .reg_wr_i(reg_wr_i),
  .stack_full_i(stack_full_i), .insn_bound_i(insn_bound_i), .ctl0_o(ctl0_o),
  .ctl1_o(ctl1_o), .take_o(take_o), .vector_o(vector_o)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_irq_ni = 1'b1;
  logic       tmr0_ovf_i = 1'b0, tmr1_ovf_i = 1'b0, ser0_i = 1'b0, ser1_i = 1'b0;
  logic [3:0] usb_evt_i = '0;
  logic       reg_wr_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic       stack_full_i = 1'b0, insn_bound_i = 1'b0;
  logic [7:0] ctl0_o, ctl1_o, vector_o;
  logic       take_o, wake_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  irq_vector_ctrl u_irq_vector_ctrl (.*);

  // row = {enables[5:0], sources[5:0], expected vector (0 = no take)}
  // source bits: 0 ext, 1 tmr0, 2 tmr1, 3 usb, 4 ser0, 5 ser1
  localparam logic [19:0] ROWS [0:7] = '{
    {6'b111111, 6'b000001, 8'h04},
    {6'b111111, 6'b000110, 8'h08},
    {6'b111111, 6'b111000, 8'h10},
    {6'b111111, 6'b110000, 8'h14},
    {6'b100000, 6'b100000, 8'h18},
    {6'b111110, 6'b111111, 8'h08},
    {6'b111011, 6'b000100, 8'h00},
    {6'b101000, 6'b101010, 8'h10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ctl0", ctl0_o, 8'h00);
    chk("R1 ctl1", ctl1_o, 8'h00);
    chk("R1 take", take_o, 0);
    chk("R1 vector", vector_o, 8'h00);
    chk("R1 wake", wake_o, 0);

    // table walk
    for (int r = 0; r < 8; r++) begin
      logic [5:0] en, src, fl;
      logic [7:0] ev;
      en = ROWS[r][19:14]; src = ROWS[r][13:8]; ev = ROWS[r][7:0];
      write_reg(1'b0, 8'h00);
      write_reg(1'b1, 8'h00);
      write_reg(1'b1, {5'b0, en[5:3]});
      write_reg(1'b0, {4'b0, en[2:0], 1'b0});
      ext_irq_ni = ~src[0]; tmr0_ovf_i = src[1]; tmr1_ovf_i = src[2];
      usb_evt_i = src[3] ? (4'b0001 << (r % 4)) : 4'b0000;
      ser0_i = src[4]; ser1_i = src[5];
      @(negedge clk_i);
      ext_irq_ni = 1'b1; tmr0_ovf_i = 0; tmr1_ovf_i = 0; usb_evt_i = '0; ser0_i = 0; ser1_i = 0;
      chk("R4 R5 R2 flags ctl0", ctl0_o, {1'b0, src[2:0], en[2:0], 1'b0});
      chk("R5 R3 flags ctl1", ctl1_o, {1'b0, src[5:3], 1'b0, en[5:3]});
      chk("R12 wake with gie off", wake_o, 1);
      chk("R10 no take with gie off", take_o, 0);
      write_reg(1'b0, {1'b0, src[2:0], en[2:0], 1'b1});
      insn_bound_i = 1'b1;
      @(negedge clk_i);
      insn_bound_i = 1'b0;
      if (ev != 8'h00) begin
        fl = src & ~(6'b000001 << ((ev >> 2) - 1));
        chk("R6 take", take_o, 1);
        chk("R7 vector", vector_o, ev);
        chk("R8 ctl0 after take", ctl0_o, {1'b0, fl[2:0], en[2:0], 1'b0});
        chk("R8 ctl1 after take", ctl1_o, {1'b0, fl[5:3], 1'b0, en[5:3]});
      end else begin
        chk("R6 no enabled source", take_o, 0);
        chk("R6 gie kept", ctl0_o[0], 1);
      end
    end

    // register layout, spare bits
    write_reg(1'b0, 8'hFF);
    chk("R2 spare bit ctl0", ctl0_o, 8'h7F);
    write_reg(1'b1, 8'hFF);
    chk("R3 spare bits ctl1", ctl1_o, 8'h77);
    chk("R6 no boundary no take", take_o, 0);
    write_reg(1'b1, 8'h00);
    write_reg(1'b0, 8'h00);
    chk("R12 no flags no wake", wake_o, 0);

    // stack full blocks, released later
    write_reg(1'b0, 8'h13);
    stack_full_i = 1'b1; insn_bound_i = 1'b1;
    @(negedge clk_i);
    chk("R9 stack full blocks", take_o, 0);
    @(negedge clk_i);
    chk("R9 still blocked", take_o, 0);
    chk("R9 request held", ctl0_o, 8'h13);
    stack_full_i = 1'b0;
    @(negedge clk_i);
    chk("R9 taken after release", take_o, 1);
    chk("R9 vector", vector_o, 8'h04);
    @(negedge clk_i);
    chk("R6 pulse one cycle", take_o, 0);
    chk("R8 gie and flag cleared", ctl0_o, 8'h02);

    // nesting: two pending, gie re-enabled twice
    write_reg(1'b0, 8'h16);
    tmr0_ovf_i = 1'b1;
    @(negedge clk_i);
    tmr0_ovf_i = 1'b0;
    chk("R10 both pending", ctl0_o, 8'h36);
    chk("R10 no take yet", take_o, 0);
    write_reg(1'b0, 8'h37);
    @(negedge clk_i);
    chk("R10 first nested take", take_o, 1);
    chk("R7 ext before tmr0", vector_o, 8'h04);
    chk("R8 tmr0 kept", ctl0_o, 8'h26);
    write_reg(1'b0, 8'h27);
    @(negedge clk_i);
    chk("R10 second nested take", take_o, 1);
    chk("R7 tmr0 vector", vector_o, 8'h08);
    chk("R8 all cleared", ctl0_o, 8'h06);
    insn_bound_i = 1'b0;

    // hardware set beats software write
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 8'h00; tmr1_ovf_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0; tmr1_ovf_i = 1'b0;
    chk("R11 tmr1 flag survives write", ctl0_o, 8'h40);
    reg_wr_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 8'h00; usb_evt_i = 4'b0100;
    @(negedge clk_i);
    reg_wr_i = 1'b0; usb_evt_i = '0;
    chk("R11 usb flag survives write", ctl1_o, 8'h10);
    write_reg(1'b1, 8'h00);
    write_reg(1'b0, 8'h00);

    // edge-only detection on the pin
    ext_irq_ni = 1'b0;
    @(negedge clk_i);
    chk("R4 falling edge sets", ctl0_o, 8'h10);
    write_reg(1'b0, 8'h00);
    @(negedge clk_i);
    chk("R4 low level does not re-set", ctl0_o, 8'h00);
    ext_irq_ni = 1'b1;
    @(negedge clk_i);
    chk("R4 rising edge ignored", ctl0_o, 8'h00);
    chk("R12 wake low", wake_o, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule